// File: doc/BRIEF.md
# Bit-Slip Aligned Sample Packer

This block sits behind a 1:8 serial-to-parallel converter and turns its byte stream into 20-bit samples. Each clock in which `in_valid` is high delivers one byte per active lane. Bits are taken most significant first, so the earliest serial bit ends up at the top of a sample. In single-lane mode only lane A carries data and each sample holds 20 consecutive lane-A bits. In dual-lane mode both lanes deliver 10 bits per sample. Lane A fills the upper half and lane B the lower half.

Word alignment is found by bit-slipping. While `slip_en` is high, the device is expected to transmit a repeating training word, set by the `TRAIN_PATTERN` parameter. Every packed sample is compared with it. On a mismatch the block drops one incoming bit. This moves the sample boundary by one bit position. The block then skips one whole sample before it compares again. Once a sample matches, `sync_done` is set and slipping stops. When `slip_en` is lowered, the alignment found is kept and `sync_done` keeps its value. Raising `slip_en` again clears `sync_done` and starts a new search. The active-low `sync_n` input tells the block that the converter clock is stopped. While it is low, all packing and alignment state is cleared.

The sample stream has no back-pressure. A serial converter cannot be stalled, so no ready input exists on either side. A downstream consumer takes `out_sample` in any cycle where `out_valid` is high, and a sample that is not taken is lost. When `filt_en` is high, `out_valid` is additionally held low while `filt_rdy_n` is high. Samples produced in that state are discarded.

Top module: `bitslip_sample_packer`

## Requirements
- R1: Single-lane packing. With `dual_lane`=0, sample k holds serial bits 20k..20k+19 of lane A. The first bit is in bit 19. Each byte is serialised bit 7 first. `out_valid` pulses in the cycle after the clock edge that accepted the byte completing the sample. Cycles with `in_valid` low neither add nor drop bits.
- R2: Dual-lane packing. With `dual_lane`=1, every sample takes 10 bits from each lane. Lane A's 10 bits go to bits 19..10 and lane B's 10 bits go to bits 9..0, each earliest bit first. The lane count may only be changed while `sync_n` is low.
- R3: With `filt_en`=1 and `filt_rdy_n`=1, `out_valid` stays low and the samples finished in that state are dropped. With `filt_rdy_n`=0, samples are delivered as in R1 and R2.
- R4: With `filt_en`=0, `filt_rdy_n` has no effect on `out_valid`.
- R5: With `slip_en`=1 and a stream of repeated `TRAIN_PATTERN` words at any bit offset, the block slips one bit at a time. It skips one sample after each slip. It eventually sets `sync_done`=1, and every later sample equals `TRAIN_PATTERN`. This holds in both lane modes.
- R6: With `slip_en`=0, no bit is ever dropped. `sync_done` keeps its value even when the incoming data stops matching the pattern.
- R7: A rising `slip_en` clears `sync_done` by the following clock edge and restarts the search. The search then reaches alignment again.
- R8: While `sync_n`=0, partially gathered bits are discarded and `out_valid` and `sync_done` read 0 from the next clock edge on. Packing restarts from an empty state after `sync_n` rises.
- R9: After reset (`rst_n`=0), `out_valid`=0 and `sync_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Low while the converter clock is stopped; clears the block |
| in_valid | input | 1 | A byte is present on each active lane |
| lane_a_word | input | WORD_W | Lane A byte, bit 7 received first |
| lane_b_word | input | WORD_W | Lane B byte, used in dual-lane mode |
| dual_lane | input | 1 | 0: lane A only, 1: both lanes |
| slip_en | input | 1 | Enables the training-pattern search |
| filt_en | input | 1 | Gates output valid with the filter ready input |
| filt_rdy_n | input | 1 | Active-low filtered-data-ready |
| out_sample | output | SAMPLE_W | Packed sample |
| out_valid | output | 1 | `out_sample` holds a new sample this cycle |
| sync_done | output | 1 | Alignment has been found |

## Verification
A wrong bit count in a lane packer shifts every later sample. The first sample delivered after the fault then compares wrong against the bit-level model, one cycle after the byte that completes it. A lane counter that drifts in dual mode breaks the lane-A/lane-B split from the next sample on. The lane lockstep assertion flags it at the very edge where the two frame strobes disagree. An aligner stuck in a wrong state shows at the ports in one of three ways. `sync_done` fails to rise within a bounded number of bytes. Samples are still misaligned after lock. Or `sync_done` moves, or bits are dropped, while `slip_en` is low. The skew injected during the frozen phase makes the last case visible within a few samples.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [2:0] {
    AL_IDLE,
    AL_HUNT,
    AL_SLIP,
    AL_SKIP,
    AL_LOCK
  } align_st_t;
endpackage

// File: rtl/bsp_lane_packer.sv
module bsp_lane_packer #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned MAX_FRAME = 20,
  parameter int unsigned CNT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    word,
  input  logic [CNT_W-1:0]     frame_len,
  input  logic                 slip,
  output logic                 frame_stb,
  output logic [MAX_FRAME-1:0] frame
);
  localparam int unsigned HOLD_W = MAX_FRAME - 1;
  localparam int unsigned EXT_W  = HOLD_W + WORD_W;

  logic [HOLD_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EXT_W-1:0]  ext;
  logic [CNT_W-1:0]  fill;
  logic [CNT_W-1:0]  shamt;

  always_comb begin
    ext       = {acc_q, word};
    // a slip discards the oldest held bit: the window simply shrinks by one
    fill      = cnt_q + CNT_W'(WORD_W) - {{(CNT_W-1){1'b0}}, slip};
    frame_stb = in_valid && (fill >= frame_len);
    shamt     = fill - frame_len;
    frame     = MAX_FRAME'(ext >> shamt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (in_valid) begin
      acc_q <= ext[HOLD_W-1:0];
      cnt_q <= frame_stb ? shamt : fill;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_FRAME)); // R1
endmodule

// File: rtl/bsp_aligner.sv
module bsp_aligner
  import bsp_pkg::*;
#(
  parameter int unsigned          SAMPLE_W      = 20,
  parameter logic [SAMPLE_W-1:0]  TRAIN_PATTERN = 'hAC5D6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                slip_en,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                slip_take,
  output logic                slip_req,
  output logic                done
);
  align_st_t st_q;

  assign slip_req = (st_q == AL_SLIP);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st_q <= AL_IDLE;
      done <= 1'b0;
    end else if (!slip_en) begin
      st_q <= AL_IDLE;
    end else begin
      unique case (st_q)
        AL_IDLE: begin
          st_q <= AL_HUNT;
          done <= 1'b0;
        end
        AL_HUNT: if (smp_stb) begin
          if (smp == TRAIN_PATTERN) begin
            st_q <= AL_LOCK;
            done <= 1'b1;
          end else begin
            st_q <= AL_SLIP;
          end
        end
        AL_SLIP: if (slip_take) st_q <= AL_SKIP;
        AL_SKIP: if (smp_stb) st_q <= AL_HUNT;
        AL_LOCK: st_q <= AL_LOCK;
        default: st_q <= AL_IDLE;
      endcase
    end
  end

  AST_FROZEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !slip_en) |=> (done == $past(done))); // R6
  AST_SLIP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slip_en) |=> !slip_req); // R6
endmodule

// File: rtl/bitslip_sample_packer.sv
module bitslip_sample_packer
  import bsp_pkg::*;
#(
  parameter int unsigned          WORD_W        = 8,
  parameter int unsigned          SAMPLE_W      = 20,
  parameter logic [SAMPLE_W-1:0]  TRAIN_PATTERN = 'hAC5D6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_n,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   lane_a_word,
  input  logic [WORD_W-1:0]   lane_b_word,
  input  logic                dual_lane,
  input  logic                slip_en,
  input  logic                filt_en,
  input  logic                filt_rdy_n,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_valid,
  output logic                sync_done
);
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned HALF_W    = SAMPLE_W / 2;
  localparam int unsigned CNT_W     = $clog2(SAMPLE_W + WORD_W);

  logic                clr;
  logic                slip_req;
  logic                slip_take;
  logic [CNT_W-1:0]    len_a;
  logic [NUM_LANES-1:0] lane_stb;
  logic [SAMPLE_W-1:0] frame_a;
  logic [HALF_W-1:0]   frame_b;
  logic [SAMPLE_W-1:0] smp_d;
  logic [SAMPLE_W-1:0] smp_q;
  logic                stb_q;

  assign clr       = !sync_n;
  assign slip_take = slip_req && in_valid;
  assign len_a     = dual_lane ? CNT_W'(HALF_W) : CNT_W'(SAMPLE_W);

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    if (gi == 0) begin : g_a
      bsp_lane_packer #(.WORD_W(WORD_W), .MAX_FRAME(SAMPLE_W), .CNT_W(CNT_W)) u_pk (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .word(lane_a_word), .frame_len(len_a),
        .slip(slip_take), .frame_stb(lane_stb[gi]), .frame(frame_a));
    end else begin : g_b
      bsp_lane_packer #(.WORD_W(WORD_W), .MAX_FRAME(HALF_W), .CNT_W(CNT_W)) u_pk (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid && dual_lane), .word(lane_b_word),
        .frame_len(CNT_W'(HALF_W)),
        .slip(slip_take && dual_lane), .frame_stb(lane_stb[gi]), .frame(frame_b));
    end
  end

  assign smp_d = dual_lane ? {frame_a[HALF_W-1:0], frame_b} : frame_a;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      smp_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= lane_stb[0];
      if (lane_stb[0]) smp_q <= smp_d;
    end
  end

  bsp_aligner #(.SAMPLE_W(SAMPLE_W), .TRAIN_PATTERN(TRAIN_PATTERN)) u_align (
    .clk(clk), .rst_n(rst_n), .clr(clr), .slip_en(slip_en),
    .smp_stb(stb_q), .smp(smp_q), .slip_take(slip_take),
    .slip_req(slip_req), .done(sync_done));

  assign out_sample = smp_q;
  assign out_valid  = stb_q && (!filt_en || !filt_rdy_n);

  AST_LANES_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (dual_lane && in_valid) |-> (lane_stb[0] == lane_stb[1])); // R2
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (!out_valid && !sync_done)); // R8
endmodule

// File: tb/sim_bitslip_sample_packer.sv
module sim_bitslip_sample_packer;
  localparam logic [19:0] PAT = 20'hAC5D6;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_n = 1'b1, in_valid = 1'b0;
  logic [7:0] wa = '0, wb = '0;
  logic dual = 1'b0, slip_en = 1'b0, filt_en = 1'b0, filt_rdy_n = 1'b1;
  logic [19:0] out_sample;
  logic out_valid, sync_done;

  int nchk = 0, nerr = 0, mode = 0, mism = 0, vcnt = 0, gp = 0;
  string cur_req = "R1";
  logic [19:0] exp_q[$];
  bit qa[$], qb[$];

  always #10 clk = ~clk;

  bitslip_sample_packer u0 (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .in_valid(in_valid),
    .lane_a_word(wa), .lane_b_word(wb), .dual_lane(dual), .slip_en(slip_en),
    .filt_en(filt_en), .filt_rdy_n(filt_rdy_n),
    .out_sample(out_sample), .out_valid(out_valid), .sync_done(sync_done));

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare delivered samples against the scoreboard or the pattern
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      vcnt++;
      if (mode == 0) begin
        if (exp_q.size() == 0) check({cur_req, " unexpected sample"}, int'(out_sample), -1);
        else check(cur_req, int'(out_sample), int'(exp_q.pop_front()));
      end else if (mode == 1) begin
        check(cur_req, int'(out_sample), int'(PAT));
      end else if (out_sample != PAT) begin
        mism++;
      end
    end
  end

  // driver: one byte per lane, reference model updated alongside
  task automatic push_word(input logic [7:0] a, input logic [7:0] b);
    logic [19:0] s;
    @(negedge clk);
    in_valid = 1'b1; wa = a; wb = b;
    for (int k = 7; k >= 0; k--) begin
      qa.push_back(a[k]);
      if (dual) qb.push_back(b[k]);
    end
    if (!dual && qa.size() >= 20) begin
      for (int k = 19; k >= 0; k--) s[k] = qa.pop_front();
      if (!filt_en || !filt_rdy_n) exp_q.push_back(s);
    end else if (dual && qa.size() >= 10) begin
      for (int k = 19; k >= 10; k--) s[k] = qa.pop_front();
      for (int k = 9; k >= 0; k--) s[k] = qb.pop_front();
      if (!filt_en || !filt_rdy_n) exp_q.push_back(s);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_pat_word();
    logic [7:0] a, b;
    for (int k = 0; k < 8; k++) begin
      a[7-k] = dual ? PAT[19 - ((gp + k) % 10)] : PAT[19 - ((gp + k) % 20)];
      b[7-k] = PAT[9 - ((gp + k) % 10)];
    end
    gp += 8;
    push_word(a, b);
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    sync_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 valid low while sync_n low", int'(out_valid), 0);
    check("R8 sync_done cleared", int'(sync_done), 0);
    qa.delete(); qb.delete(); exp_q.delete();
    sync_n = 1'b1;
  endtask

  task automatic drain(string req);
    idle(4);
    check({req, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  task automatic acquire(string req);
    int n = 0;
    while (!sync_done && n < 600) begin
      send_pat_word();
      n++;
    end
    check({req, " lock reached"}, int'(sync_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog req=all actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 sync_done after reset", int'(sync_done), 0);

    // R1: single lane, gapped and back-to-back bytes
    cur_req = "R1"; mode = 0;
    for (int i = 0; i < 25; i++) begin
      push_word(8'(i * 37 + 5), 8'h00);
      if (i % 4 == 3) idle(2);
    end
    drain("R1");

    // R8: partial bits dropped by sync_n
    cur_req = "R8";
    push_word(8'hFF, 8'h00);
    sync_pulse();
    for (int i = 0; i < 10; i++) push_word(8'(8'h3C ^ (i * 11)), 8'h00);
    drain("R8");

    // R2: dual lane
    @(negedge clk); sync_n = 1'b0; in_valid = 1'b0; dual = 1'b1;
    sync_pulse();
    cur_req = "R2";
    for (int i = 0; i < 20; i++) push_word(8'(i * 29 + 1), 8'(8'hA5 ^ (i * 7)));
    drain("R2");

    // R3: filter gating
    cur_req = "R3"; filt_en = 1'b1; filt_rdy_n = 1'b1; idle(2);
    vcnt = 0;
    for (int i = 0; i < 10; i++) push_word(8'(i + 100), 8'(i + 50));
    idle(4);
    check("R3 no valid while ready high", vcnt, 0);
    filt_rdy_n = 1'b0; idle(2);
    for (int i = 0; i < 10; i++) push_word(8'(i * 3), 8'(i * 5 + 9));
    drain("R3");

    // R4: filter disabled, ready ignored
    cur_req = "R4"; filt_en = 1'b0; filt_rdy_n = 1'b1; idle(2);
    vcnt = 0;
    for (int i = 0; i < 10; i++) push_word(8'(i * 13), 8'(i * 17));
    drain("R4");
    check("R4 samples delivered", int'(vcnt > 0), 1);

    // R5: dual-lane alignment at an arbitrary offset
    cur_req = "R5"; mode = 2; gp = 3; slip_en = 1'b1;
    acquire("R5 dual");
    mode = 1;
    for (int i = 0; i < 15; i++) send_pat_word();
    idle(3);

    // R5: single-lane alignment
    @(negedge clk); slip_en = 1'b0; sync_n = 1'b0; dual = 1'b0;
    sync_pulse();
    mode = 2; gp = 13; slip_en = 1'b1;
    acquire("R5 single");
    mode = 1; vcnt = 0;
    for (int i = 0; i < 25; i++) send_pat_word();
    check("R5 aligned samples seen", int'(vcnt > 0), 1);

    // R6: freeze, then skew the stream
    cur_req = "R6"; slip_en = 1'b0;
    for (int i = 0; i < 10; i++) send_pat_word();
    check("R6 done held", int'(sync_done), 1);
    mode = 2; mism = 0; gp += 3;
    for (int i = 0; i < 25; i++) send_pat_word();
    idle(2);
    check("R6 done held after skew", int'(sync_done), 1);
    check("R6 no realignment while frozen", int'(mism > 0), 1);

    // R7: re-enable clears and reacquires
    cur_req = "R7"; slip_en = 1'b1;
    send_pat_word();
    check("R7 done cleared on re-enable", int'(sync_done), 0);
    acquire("R7");
    mode = 1;
    for (int i = 0; i < 15; i++) send_pat_word();
    idle(3);

    // R8: sync_n clears a locked state
    cur_req = "R8"; slip_en = 1'b0; mode = 0;
    sync_pulse();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule